// File: doc/BRIEF.md
# Three-Wire Synthesizer Register Loader

This block takes 24-bit programming words from a three-pin serial link (data, shift clock, latch strobe). All three pins are sampled in the system clock domain. Each rising edge of the shift clock moves one data bit into a shift register, most significant bit first. A rising edge of the latch strobe ends the word. The word's two least significant bits are then read as an address, and the remaining 22 payload bits are written into one of three holding registers: control, reference divider or feedback divider.

Each holding register is brought out whole and also split into its decoded fields. Each register has its own load pulse, one system clock wide, in the cycle its new value first appears. Address code 3 names a test register that does not exist, so it changes nothing. The shift register always keeps the most recent 24 bits. A strobe after a short or long burst therefore uses whatever those 24 bits are.

Top module: `syn_word_loader`

## Requirements
- R1: After reset, all three holding registers and every decoded field are zero, and no load pulse is high.
- R2: A word is shifted in MSB first. One bit of `ser_data` is taken on each rising edge of `ser_clk`, so word bit 23 arrives first and bit 0 arrives last.
- R3: A strobe with word bits [1:0] = 0 writes word bits [23:2] into `ctl_q`. The decoded fields are `ctl_prescale` = word[23:22], `ctl_pdown` = word[21:20] and `ctl_mute_lock` = word[11].
- R4: A strobe with word bits [1:0] = 1 writes word bits [23:2] into `ref_q`. The decoded fields are `ref_ratio` = word[15:2] and `ref_rsvd` = word[23:22]. The reserved bits are passed through unchanged.
- R5: A strobe with word bits [1:0] = 2 writes word bits [23:2] into `fb_q`. The decoded fields are `fb_a` = word[6:2], `fb_b` = word[20:8] and `fb_div2` = word[22].
- R6: A strobe with word bits [1:0] = 3 leaves all three registers unchanged and raises no load pulse.
- R7: A strobe uses the last 24 bits shifted in, whether more or fewer than 24 bits were sent since the previous strobe.
- R8: Each write raises only the target register's load pulse, for exactly one clock cycle. The other two registers keep their values.
- R9: Falling edges of `ser_clk` and `ser_le`, and changes on `ser_data` while `ser_clk` is steady, do not alter the shift contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_data | input | 1 | Serial data pin |
| ser_clk | input | 1 | Serial shift clock pin |
| ser_le | input | 1 | Latch strobe pin |
| ctl_q | output | 22 | Control register payload |
| ctl_prescale | output | 2 | Prescaler select field |
| ctl_pdown | output | 2 | Power-down mode field |
| ctl_mute_lock | output | 1 | Mute-until-lock enable |
| ref_q | output | 22 | Reference divider register payload |
| ref_ratio | output | 14 | Reference divide ratio |
| ref_rsvd | output | 2 | Reserved bits, passed through |
| fb_q | output | 22 | Feedback divider register payload |
| fb_a | output | 5 | Feedback A count |
| fb_b | output | 13 | Feedback B count |
| fb_div2 | output | 1 | Output divide-by-two select |
| load_ctl | output | 1 | Control register load pulse |
| load_ref | output | 1 | Reference register load pulse |
| load_fb | output | 1 | Feedback register load pulse |

## Verification
The three routed addresses are each tried with words that have distinct, asymmetric bit patterns. A lost bit, a reversed bit order or a misplaced field therefore shows up as a wrong field value, and the untouched registers show any routing to the wrong target. Address 3 is sent after known values are in place, to tell an ignored write from a silent overwrite. Bursts of 30 and 8 bits separate "last 24 bits" behaviour from counting bits since the last strobe. Toggling data and making falling clock and strobe edges, followed by a re-strobe, shows that only rising shift edges move the register.

// File: rtl/syn_loader_pkg.sv
package syn_loader_pkg;
  parameter int WORD_W  = 24;
  parameter int ADDR_W  = 2;
  parameter int PAY_W   = WORD_W - ADDR_W;
  parameter int NUM_LAT = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADR_CTL  = 2'd0,
    ADR_REF  = 2'd1,
    ADR_FB   = 2'd2,
    ADR_TEST = 2'd3
  } lat_addr_e;

  // payload bit k corresponds to word bit k+ADDR_W
  function automatic logic [1:0] f_prescale(input logic [PAY_W-1:0] p);
    return p[21:20];
  endfunction

  function automatic logic [1:0] f_pdown(input logic [PAY_W-1:0] p);
    return p[19:18];
  endfunction

  function automatic logic f_mute(input logic [PAY_W-1:0] p);
    return p[9];
  endfunction

  function automatic logic [13:0] f_ratio(input logic [PAY_W-1:0] p);
    return p[13:0];
  endfunction

  function automatic logic [1:0] f_rsvd(input logic [PAY_W-1:0] p);
    return p[21:20];
  endfunction

  function automatic logic [4:0] f_acnt(input logic [PAY_W-1:0] p);
    return p[4:0];
  endfunction

  function automatic logic [12:0] f_bcnt(input logic [PAY_W-1:0] p);
    return p[18:6];
  endfunction

  function automatic logic f_div2(input logic [PAY_W-1:0] p);
    return p[20];
  endfunction
endpackage

// File: rtl/pin_sampler.sv
module pin_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_data,
  input  logic ser_clk,
  input  logic ser_le,
  output logic data_s,
  output logic shift_rise,
  output logic le_rise
);
  // bit 0 data, bit 1 shift clock, bit 2 latch strobe
  logic [STAGES:0][2:0] pipe;

  always_ff @(posedge clk) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-1:0], {ser_le, ser_clk, ser_data}};
  end

  assign data_s     = pipe[STAGES-1][0];
  assign shift_rise = pipe[STAGES-1][1] & ~pipe[STAGES][1];
  assign le_rise    = pipe[STAGES-1][2] & ~pipe[STAGES][2];

  // R9: an edge is a single-cycle event
  a_r9_single_shift: assert property (@(posedge clk) disable iff (!rst_n)
    shift_rise |=> !shift_rise);
  a_r9_single_le: assert property (@(posedge clk) disable iff (!rst_n)
    le_rise |=> !le_rise);
endmodule

// File: rtl/word_shifter.sv
module word_shifter #(
  parameter int WORD_W = syn_loader_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              din,
  output logic [WORD_W-1:0] word_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)        word_q <= '0;
    else if (shift_en) word_q <= {word_q[WORD_W-2:0], din};
  end

  // R9: no shift edge, no movement
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(word_q));
  // R2: older bits move toward the MSB
  a_r2_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> word_q[WORD_W-1:1] == $past(word_q[WORD_W-2:0]));
endmodule

// File: rtl/latch_bank.sv
module latch_bank #(
  parameter int ADDR_W  = syn_loader_pkg::ADDR_W,
  parameter int PAY_W   = syn_loader_pkg::PAY_W,
  parameter int NUM_LAT = syn_loader_pkg::NUM_LAT
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [PAY_W-1:0]              payload,
  output logic [NUM_LAT-1:0][PAY_W-1:0] lat_q,
  output logic [NUM_LAT-1:0]            load_q
);
  logic [NUM_LAT-1:0] hit;

  for (genvar i = 0; i < NUM_LAT; i++) begin : g_lat
    assign hit[i] = wr_en && (addr == ADDR_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lat_q[i]  <= '0;
        load_q[i] <= 1'b0;
      end else begin
        load_q[i] <= hit[i];
        if (hit[i]) lat_q[i] <= payload;
      end
    end

    // R8: a register changes only when its own pulse follows
    a_r8_only_target: assert property (@(posedge clk) disable iff (!rst_n)
      !hit[i] |=> $stable(lat_q[i]));
    // R8: pulse lasts one cycle
    a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      load_q[i] |=> !load_q[i]);
  end

  // R8: at most one register loads at a time
  a_r8_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_q));
  // R6: the test code loads nothing
  a_r6_test_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == syn_loader_pkg::ADR_TEST) |=> (load_q == '0 && $stable(lat_q)));
endmodule

// File: rtl/syn_word_loader.sv
module syn_word_loader
  import syn_loader_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_data,
  input  logic              ser_clk,
  input  logic              ser_le,
  output logic [PAY_W-1:0]  ctl_q,
  output logic [1:0]        ctl_prescale,
  output logic [1:0]        ctl_pdown,
  output logic              ctl_mute_lock,
  output logic [PAY_W-1:0]  ref_q,
  output logic [13:0]       ref_ratio,
  output logic [1:0]        ref_rsvd,
  output logic [PAY_W-1:0]  fb_q,
  output logic [4:0]        fb_a,
  output logic [12:0]       fb_b,
  output logic              fb_div2,
  output logic              load_ctl,
  output logic              load_ref,
  output logic              load_fb
);
  logic                          data_s;
  logic                          shift_rise;
  logic                          le_rise;
  logic [WORD_W-1:0]             word_q;
  logic [NUM_LAT-1:0][PAY_W-1:0] lat_q;
  logic [NUM_LAT-1:0]            load_q;

  pin_sampler #(.STAGES(SYNC_STAGES)) u_pins (
    .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk),
    .ser_le(ser_le), .data_s(data_s), .shift_rise(shift_rise), .le_rise(le_rise)
  );

  word_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_rise), .din(data_s), .word_q(word_q)
  );

  latch_bank #(.ADDR_W(ADDR_W), .PAY_W(PAY_W), .NUM_LAT(NUM_LAT)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(le_rise),
    .addr(word_q[ADDR_W-1:0]), .payload(word_q[WORD_W-1:ADDR_W]),
    .lat_q(lat_q), .load_q(load_q)
  );

  assign ctl_q    = lat_q[ADR_CTL];
  assign ref_q    = lat_q[ADR_REF];
  assign fb_q     = lat_q[ADR_FB];
  assign load_ctl = load_q[ADR_CTL];
  assign load_ref = load_q[ADR_REF];
  assign load_fb  = load_q[ADR_FB];

  assign ctl_prescale  = f_prescale(ctl_q);
  assign ctl_pdown     = f_pdown(ctl_q);
  assign ctl_mute_lock = f_mute(ctl_q);
  assign ref_ratio     = f_ratio(ref_q);
  assign ref_rsvd      = f_rsvd(ref_q);
  assign fb_a          = f_acnt(fb_q);
  assign fb_b          = f_bcnt(fb_q);
  assign fb_div2       = f_div2(fb_q);

  // R3, R4, R5: a pulse shows the word that was in the shifter at the strobe
  a_r3_ctl_value: assert property (@(posedge clk) disable iff (!rst_n)
    load_ctl |-> ctl_q == $past(word_q[WORD_W-1:ADDR_W]));
  a_r4_ref_value: assert property (@(posedge clk) disable iff (!rst_n)
    load_ref |-> ref_q == $past(word_q[WORD_W-1:ADDR_W]));
  a_r5_fb_value: assert property (@(posedge clk) disable iff (!rst_n)
    load_fb |-> fb_q == $past(word_q[WORD_W-1:ADDR_W]));
endmodule

// File: tb/syn_word_loader_test.sv
module syn_word_loader_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_data = 1'b0, ser_clk = 1'b0, ser_le = 1'b0;
  logic [21:0] ctl_q, ref_q, fb_q;
  logic [1:0]  ctl_prescale, ctl_pdown, ref_rsvd;
  logic        ctl_mute_lock, fb_div2, load_ctl, load_ref, load_fb;
  logic [13:0] ref_ratio;
  logic [4:0]  fb_a;
  logic [12:0] fb_b;

  syn_word_loader uut (
    .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk), .ser_le(ser_le),
    .ctl_q(ctl_q), .ctl_prescale(ctl_prescale), .ctl_pdown(ctl_pdown),
    .ctl_mute_lock(ctl_mute_lock), .ref_q(ref_q), .ref_ratio(ref_ratio),
    .ref_rsvd(ref_rsvd), .fb_q(fb_q), .fb_a(fb_a), .fb_b(fb_b), .fb_div2(fb_div2),
    .load_ctl(load_ctl), .load_ref(load_ref), .load_fb(load_fb)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0, cycles = 0;
  bit done = 0;
  int cnt_ctl = 0, cnt_ref = 0, cnt_fb = 0, wide_pulse = 0;
  logic pl_ctl = 0, pl_ref = 0, pl_fb = 0;

  // bench model
  logic [23:0] m_sh = '0;
  logic [23:0] m_ctl = '0, m_ref = '0, m_fb = '0;  // full words last routed
  int e_ctl = 0, e_ref = 0, e_fb = 0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (load_ctl) cnt_ctl <= cnt_ctl + 1;
    if (load_ref) cnt_ref <= cnt_ref + 1;
    if (load_fb)  cnt_fb  <= cnt_fb + 1;
    if ((load_ctl && pl_ctl) || (load_ref && pl_ref) || (load_fb && pl_fb))
      wide_pulse <= wide_pulse + 1;
    pl_ctl <= load_ctl; pl_ref <= load_ref; pl_fb <= load_fb;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bit(input logic b);
    ser_data = b;  wait_clk(5);
    ser_clk = 1'b1; wait_clk(5);
    ser_clk = 1'b0; wait_clk(5);
    m_sh = {m_sh[22:0], b};
  endtask

  task automatic send_bits(input logic [31:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) shift_bit(w[i]);
  endtask

  task automatic strobe();
    ser_le = 1'b1; wait_clk(8);
    ser_le = 1'b0; wait_clk(8);
    case (m_sh[1:0])
      2'd0: begin m_ctl = m_sh; e_ctl++; end
      2'd1: begin m_ref = m_sh; e_ref++; end
      2'd2: begin m_fb  = m_sh; e_fb++;  end
      default: ;
    endcase
  endtask

  task automatic check_all(input string tag);
    check({tag, " ctl_q"}, ctl_q, m_ctl[23:2]);
    check({tag, " ref_q"}, ref_q, m_ref[23:2]);
    check({tag, " fb_q"},  fb_q,  m_fb[23:2]);
    check({tag, " cnt_ctl"}, cnt_ctl, e_ctl);
    check({tag, " cnt_ref"}, cnt_ref, e_ref);
    check({tag, " cnt_fb"},  cnt_fb,  e_fb);
  endtask

  task automatic t_reset();
    check("R1 ctl_q", ctl_q, 0);
    check("R1 ref_q", ref_q, 0);
    check("R1 fb_q", fb_q, 0);
    check("R1 fields", {ctl_prescale, ctl_pdown, ctl_mute_lock, ref_ratio, ref_rsvd,
                        fb_a, fb_b, fb_div2}, 0);
    check("R1 loads", {load_ctl, load_ref, load_fb}, 0);
  endtask

  task automatic t_ctrl();
    logic [23:0] w = 24'b10_01_0000_1010_1000_0110_00;
    send_bits(w, 24); strobe();
    check_all("R3 R2");
    check("R3 prescale", ctl_prescale, w[23:22]);
    check("R3 pdown", ctl_pdown, w[21:20]);
    check("R3 mute", ctl_mute_lock, w[11]);
  endtask

  task automatic t_ref();
    logic [23:0] w = {2'b10, 6'b000000, 14'h2A5B, 2'b01};
    send_bits(w, 24); strobe();
    check_all("R4 R8");
    check("R4 ratio", ref_ratio, 14'h2A5B);
    check("R4 rsvd", ref_rsvd, 2'b10);
  endtask

  task automatic t_fb();
    logic [23:0] w = {1'b0, 1'b1, 1'b0, 13'h1C3A, 1'b1, 5'b10011, 2'b10};
    send_bits(w, 24); strobe();
    check_all("R5 R8");
    check("R5 a", fb_a, 5'b10011);
    check("R5 b", fb_b, 13'h1C3A);
    check("R5 div2", fb_div2, 1'b1);
  endtask

  task automatic t_test_ignored();
    send_bits(32'hFFFFFF, 24); strobe();
    check_all("R6 ignored");
  endtask

  task automatic t_long();
    // 6 extra leading bits must be dropped
    send_bits({2'b00, 6'b101101, 22'h15A3C7, 2'b00}, 30); strobe();
    check_all("R7 long");
    check("R7 long ctl", ctl_q, 22'h15A3C7);
  endtask

  task automatic t_short();
    // 8 bits after previous word: old low 16 bits then new 8
    send_bits(32'h0000_00C1, 8); strobe();
    check_all("R7 short");
  endtask

  task automatic t_glitch();
    for (int i = 0; i < 4; i++) begin ser_data = ~ser_data; wait_clk(5); end
    ser_clk = 1'b1; ser_data = 1'b0; wait_clk(5);   // rising edge: one bit
    m_sh = {m_sh[22:0], 1'b0};
    ser_data = 1'b1; wait_clk(5);                   // data moves while high
    ser_clk = 1'b0; wait_clk(5);                    // falling edge
    ser_le = 1'b1; wait_clk(5); ser_le = 1'b0; wait_clk(3);
    // the strobe above moved through the model as well
    case (m_sh[1:0])
      2'd0: begin m_ctl = m_sh; e_ctl++; end
      2'd1: begin m_ref = m_sh; e_ref++; end
      2'd2: begin m_fb  = m_sh; e_fb++;  end
      default: ;
    endcase
    wait_clk(5);
    check_all("R9 glitch");
    strobe();
    check_all("R9 restrobe");
  endtask

  initial begin
    wait_clk(4); rst_n = 1'b1; wait_clk(4);
    t_reset();
    t_ctrl();
    t_ref();
    t_fb();
    t_test_ignored();
    t_long();
    t_short();
    t_glitch();
    check("R8 pulse width", wide_pulse, 0);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (cycles > 150000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule